// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Controller

This block keeps the current privilege level of a small RISC-V-style core and decides where the fetch unit goes when a synchronous trap or a machine return happens. Three single-cycle strobes arrive from decode: an environment call, an illegal instruction that was already decoded outside this block, and a machine return. The PC of the instruction that raised the strobe comes in alongside them. The block also holds the four machine CSRs involved: the trap vector, the exception PC, the cause, and the previous-privilege field of the status word. Software reaches these through a simple write port and a combinational read port.

A trap sends the core into machine mode. It saves the faulting PC and the privilege the core came from, records a cause code and redirects fetch to the trap vector. A machine return redirects fetch to the saved PC and drops the core back to the privilege held in the previous-privilege field. The redirect request is registered and lasts exactly one cycle for each accepted event.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the privilege output is 3 (machine), and every CSR reads 0. `redirect_o` is 0.
- R2: When a trap strobe (`ecall_i` or `illegal_i`) is sampled at a clock edge, `redirect_o` is 1 for the following cycle only. In that cycle `redirect_pc_o` equals the trap vector value held before that edge.
- R3: On trap entry the privilege becomes 3. The exception PC takes `fault_pc_i` with bits 1:0 cleared. The status bits 12:11 take the privilege that was current at the trap.
- R4: An environment call writes cause 8 when taken from privilege 0 (user), 9 from privilege 1 (supervisor) and 11 from privilege 3 (machine).
- R5: An illegal-instruction trap writes cause 2. If `illegal_i` and `ecall_i` are sampled together, the cause is 2.
- R6: A machine return with no trap in the same cycle does three things. It gives a one-cycle redirect to the exception PC held before the edge. It sets the privilege to the value in status bits 12:11. It clears those bits to 0.
- R7: If a trap strobe and `mret_i` are sampled at the same edge, only the trap is taken. The redirect goes to the trap vector, the privilege becomes 3, and status bits 12:11 take the old privilege.
- R8: CSR select codes are 0 trap vector, 1 exception PC, 2 cause, 3 status. Reads are combinational. A write takes effect at the next edge. The trap vector and cause store all bits written (writing 9 to the cause reads back 9).
- R9: The status CSR stores only bits 12:11, and all its other bits read 0. A written field value of 2 is stored as 0, so the privilege never becomes 2.
- R10: Bits 1:0 of the exception PC always read 0, including after a software write.
- R11: When a trap or a return updates the exception PC, cause or status in the same cycle as a software write to that register, the hardware update is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecall_i | input | 1 | Environment-call strobe |
| illegal_i | input | 1 | Illegal-instruction strobe |
| mret_i | input | 1 | Machine-return strobe |
| fault_pc_i | input | XLEN | PC of the instruction raising the strobe |
| csr_we_i | input | 1 | CSR write enable |
| csr_wsel_i | input | 2 | CSR write select |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rsel_i | input | 2 | CSR read select |
| csr_rdata_o | output | XLEN | CSR read data |
| redirect_o | output | 1 | One-cycle fetch redirect request |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |

## Verification
The assertions assume only that the strobes are sampled once per edge. They do not assume that they never overlap, so trap and return collisions are legal input. Privilege legality rests entirely on how status writes are legalized. The stimulus therefore writes arbitrary 32-bit status values, including field value 2. It reaches user and supervisor mode only by returning through values that software wrote into the field. Random strobes and CSR writes often land in the same cycle, which exercises the precedence rules. Directed cases pin the environment-call cause for each privilege level.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] SEL_VEC    = 2'd0;
  localparam logic [1:0] SEL_EPC    = 2'd1;
  localparam logic [1:0] SEL_CAUSE  = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;

  localparam int PREV_LSB = 11;
  localparam int PREV_MSB = 12;

  localparam logic [4:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [4:0] CAUSE_ECALL_U = 5'd8;
  localparam logic [4:0] CAUSE_ECALL_S = 5'd9;
  localparam logic [4:0] CAUSE_ECALL_M = 5'd11;

  // Cause code of an environment call, by the privilege it came from.
  function automatic logic [4:0] ecall_cause(input logic [1:0] p);
    case (p)
      PRIV_U:  return CAUSE_ECALL_U;
      PRIV_S:  return CAUSE_ECALL_S;
      default: return CAUSE_ECALL_M;
    endcase
  endfunction

  // Legal previous-privilege value: the reserved encoding collapses to user.
  function automatic logic [1:0] legal_priv(input logic [1:0] p);
    return (p == 2'd2) ? PRIV_U : p;
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import priv_trap_pkg::*;
(
  input  logic       ecall_i,
  input  logic       illegal_i,
  input  logic       mret_i,
  input  logic [1:0] priv_i,
  output logic       trap_take_o,
  output logic       mret_take_o,
  output logic [4:0] cause_o
);
  always_comb begin
    trap_take_o = ecall_i | illegal_i;
    mret_take_o = mret_i & ~trap_take_o;
    cause_o     = illegal_i ? CAUSE_ILLEGAL : ecall_cause(priv_i);
  end
endmodule

// File: rtl/priv_csr_regs.sv
module priv_csr_regs
  import priv_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_take_i,
  input  logic            mret_take_i,
  input  logic [4:0]      cause_i,
  input  logic [XLEN-1:0] fault_pc_i,
  input  logic            csr_we_i,
  input  logic [1:0]      csr_wsel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic [1:0]      csr_rsel_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic [XLEN-1:0] vec_o,
  output logic [XLEN-1:0] epc_o,
  output logic [1:0]      priv_o
);
  localparam int CAUSE_W = 5;

  logic [XLEN-1:0] vec_q, epc_q, cause_q;
  logic [1:0]      prev_q, priv_q;
  logic            wr_vec, wr_epc, wr_cause, wr_status;

  always_comb begin
    wr_vec    = csr_we_i && (csr_wsel_i == SEL_VEC);
    wr_epc    = csr_we_i && (csr_wsel_i == SEL_EPC);
    wr_cause  = csr_we_i && (csr_wsel_i == SEL_CAUSE);
    wr_status = csr_we_i && (csr_wsel_i == SEL_STATUS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q   <= '0;
      epc_q   <= '0;
      cause_q <= '0;
      prev_q  <= PRIV_U;
      priv_q  <= PRIV_M;
    end else begin
      if (wr_vec) vec_q <= csr_wdata_i;
      if (trap_take_i) begin
        epc_q   <= {fault_pc_i[XLEN-1:2], 2'b00};
        cause_q <= {{(XLEN-CAUSE_W){1'b0}}, cause_i};
        prev_q  <= priv_q;
        priv_q  <= PRIV_M;
      end else begin
        if (wr_epc)   epc_q   <= {csr_wdata_i[XLEN-1:2], 2'b00};
        if (wr_cause) cause_q <= csr_wdata_i;
        if (mret_take_i) begin
          priv_q <= prev_q;
          prev_q <= PRIV_U;
        end else if (wr_status) begin
          prev_q <= legal_priv(csr_wdata_i[PREV_MSB:PREV_LSB]);
        end
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    case (csr_rsel_i)
      SEL_VEC:   csr_rdata_o = vec_q;
      SEL_EPC:   csr_rdata_o = epc_q;
      SEL_CAUSE: csr_rdata_o = cause_q;
      default:   csr_rdata_o[PREV_MSB:PREV_LSB] = prev_q;
    endcase
  end

  assign vec_o  = vec_q;
  assign epc_o  = epc_q;
  assign priv_o = priv_q;

  AST_TRAP_ENTERS_M: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take_i |=> priv_q == PRIV_M); // R3
  AST_TRAP_SAVES_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take_i |=> prev_q == $past(priv_q)); // R3
  AST_MRET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    mret_take_i |=> priv_q == $past(prev_q)); // R6
  AST_MRET_CLEARS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    mret_take_i |=> prev_q == PRIV_U); // R6
  AST_EPC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    epc_q[1:0] == 2'b00); // R10
  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q != 2'd2); // R9
endmodule

// File: rtl/redirect_gen.sv
module redirect_gen #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_take_i,
  input  logic            mret_take_i,
  input  logic [XLEN-1:0] vec_i,
  input  logic [XLEN-1:0] epc_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      redirect_o <= trap_take_i | mret_take_i;
      if (trap_take_i)      redirect_pc_o <= vec_i;
      else if (mret_take_i) redirect_pc_o <= epc_i;
    end
  end

  AST_REDIRECT_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take_i | mret_take_i) |=> redirect_o); // R2
  AST_REDIRECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_take_i | mret_take_i) |=> !redirect_o); // R2
  AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take_i |=> redirect_pc_o == $past(vec_i)); // R7
  AST_MRET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mret_take_i |=> redirect_pc_o == $past(epc_i)); // R6
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ecall_i,
  input  logic            illegal_i,
  input  logic            mret_i,
  input  logic [XLEN-1:0] fault_pc_i,
  input  logic            csr_we_i,
  input  logic [1:0]      csr_wsel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic [1:0]      csr_rsel_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [1:0]      priv_o
);
  logic            trap_take, mret_take;
  logic [4:0]      trap_cause;
  logic [XLEN-1:0] vec, epc;

  trap_arbiter u_arb (
    .ecall_i     (ecall_i),
    .illegal_i   (illegal_i),
    .mret_i      (mret_i),
    .priv_i      (priv_o),
    .trap_take_o (trap_take),
    .mret_take_o (mret_take),
    .cause_o     (trap_cause)
  );

  priv_csr_regs #(.XLEN(XLEN)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_take_i (trap_take),
    .mret_take_i (mret_take),
    .cause_i     (trap_cause),
    .fault_pc_i  (fault_pc_i),
    .csr_we_i    (csr_we_i),
    .csr_wsel_i  (csr_wsel_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rsel_i  (csr_rsel_i),
    .csr_rdata_o (csr_rdata_o),
    .vec_o       (vec),
    .epc_o       (epc),
    .priv_o      (priv_o)
  );

  redirect_gen #(.XLEN(XLEN)) u_redir (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_take_i   (trap_take),
    .mret_take_i   (mret_take),
    .vec_i         (vec),
    .epc_i         (epc),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  AST_COLLISION_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ecall_i && mret_i) |=> priv_o == PRIV_M); // R7
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_i && csr_rsel_i == SEL_CAUSE) |=> (csr_rsel_i != SEL_CAUSE) || csr_rdata_o == 32'd2); // R5
endmodule

// File: tb/priv_trap_ctrl_test.sv
module priv_trap_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ecall_i = 0, illegal_i = 0, mret_i = 0, csr_we_i = 0;
  logic [XLEN-1:0] fault_pc_i = '0, csr_wdata_i = '0;
  logic [1:0]      csr_wsel_i = '0, csr_rsel_i = '0;
  logic [XLEN-1:0] csr_rdata_o, redirect_pc_o;
  logic            redirect_o;
  logic [1:0]      priv_o;

  int checks = 0;
  int failures = 0;

  // Reference state
  logic [XLEN-1:0] m_vec, m_epc, m_cause;
  logic [1:0]      m_prev, m_priv;
  logic            x_redir;
  logic [XLEN-1:0] x_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_trap_ctrl #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .ecall_i(ecall_i), .illegal_i(illegal_i),
    .mret_i(mret_i), .fault_pc_i(fault_pc_i), .csr_we_i(csr_we_i),
    .csr_wsel_i(csr_wsel_i), .csr_wdata_i(csr_wdata_i), .csr_rsel_i(csr_rsel_i),
    .csr_rdata_o(csr_rdata_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .priv_o(priv_o)
  );

  function automatic logic [XLEN-1:0] exp_read(input logic [1:0] s);
    if (s == 2'd0) return m_vec;
    if (s == 2'd1) return m_epc;
    if (s == 2'd2) return m_cause;
    return {19'd0, m_prev, 11'd0};
  endfunction

  function automatic logic [XLEN-1:0] exp_ecall(input logic [1:0] p);
    return (p == 2'd0) ? 32'd8 : (p == 2'd1) ? 32'd9 : 32'd11;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One cycle: at negedge, check outputs, drive, advance reference, step.
  task automatic step(input logic ec, input logic il, input logic mr,
                      input logic [XLEN-1:0] pc, input logic we,
                      input logic [1:0] ws, input logic [XLEN-1:0] wd,
                      input logic [1:0] rs);
    logic trap, ret;
    logic [1:0] f;
    ecall_i = ec; illegal_i = il; mret_i = mr; fault_pc_i = pc;
    csr_we_i = we; csr_wsel_i = ws; csr_wdata_i = wd; csr_rsel_i = rs;
    #1;
    check("R8 csr read", csr_rdata_o, exp_read(rs));
    check("R3 R6 priv", {30'd0, priv_o}, {30'd0, m_priv});
    trap = ec | il;
    ret  = mr & ~trap;
    x_redir = trap | ret;
    x_pc = trap ? m_vec : m_epc;
    if (trap) begin
      m_epc   = pc & ~32'h3;
      m_cause = il ? 32'd2 : exp_ecall(m_priv);
      m_prev  = m_priv;
      m_priv  = 2'd3;
    end else begin
      if (we && ws == 2'd1) m_epc = wd & ~32'h3;
      if (we && ws == 2'd2) m_cause = wd;
      if (ret) begin
        m_priv = m_prev;
        m_prev = 2'd0;
      end else if (we && ws == 2'd3) begin
        f = wd[12:11];
        m_prev = (f == 2'b10) ? 2'b00 : f;
      end
    end
    if (we && ws == 2'd0) m_vec = wd;
    @(posedge clk);
    @(negedge clk);
    check("R2 redirect", {31'd0, redirect_o}, {31'd0, x_redir});
    if (x_redir) check("R2 R6 R7 target", redirect_pc_o, x_pc);
  endtask

  task automatic idle(input logic [1:0] rs);
    step(0, 0, 0, '0, 0, 2'd0, '0, rs);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_vec = '0; m_epc = '0; m_cause = '0; m_prev = 2'd0; m_priv = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 priv", {30'd0, priv_o}, 32'd3);
    check("R1 redirect", {31'd0, redirect_o}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      csr_rsel_i = s[1:0]; #1;
      check("R1 csr zero", csr_rdata_o, 32'd0);
    end
    // R8 cause plain read/write, trap vector full width
    step(0, 0, 0, '0, 1, 2'd2, 32'd9, 2'd2);
    idle(2'd2);
    step(0, 0, 0, '0, 1, 2'd0, 32'h8000_0100, 2'd0);
    // R10 exception PC write clears low bits
    step(0, 0, 0, '0, 1, 2'd1, 32'h0000_2003, 2'd1);
    idle(2'd1);
    // R9 status: field value 2 -> 0, other bits ignored
    step(0, 0, 0, '0, 1, 2'd3, 32'hFFFF_F7FF, 2'd3);
    idle(2'd3);
    // R4 ecall from machine -> 11
    step(1, 0, 0, 32'h0000_0040, 0, 2'd0, '0, 2'd2);
    idle(2'd2);
    // go to supervisor: status field 1 (0x800), return
    step(0, 0, 0, '0, 1, 2'd3, 32'h0000_0800, 2'd3);
    step(0, 0, 1, '0, 0, 2'd0, '0, 2'd3);
    idle(2'd3);  // R6 field cleared to 0
    // R4 ecall from supervisor -> 9
    step(1, 0, 0, 32'h0000_0107, 0, 2'd0, '0, 2'd2);
    idle(2'd2);
    idle(2'd3);  // R3 prev field = 1
    // go to user via return (field now 1)... set to 0 then return
    step(0, 0, 0, '0, 1, 2'd3, 32'h0, 2'd3);
    step(0, 0, 1, '0, 0, 2'd0, '0, 2'd0);
    // R4 ecall from user -> 8; R5 illegal with ecall -> 2
    step(1, 0, 0, 32'h0000_0204, 0, 2'd0, '0, 2'd2);
    idle(2'd2);
    step(1, 1, 0, 32'h0000_0300, 0, 2'd0, '0, 2'd2);
    idle(2'd2);
    // R7 trap and return together; R11 software write in same cycle loses
    step(1, 0, 1, 32'h0000_0404, 1, 2'd1, 32'h0000_9999, 2'd1);
    idle(2'd1);
    step(0, 1, 0, 32'h0000_0500, 1, 2'd2, 32'h0000_0077, 2'd2);
    idle(2'd2);
    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic ec, il, mr, we;
      logic [1:0] ws, rs;
      logic [XLEN-1:0] wd;
      ec = ($urandom % 8) == 0;
      il = ($urandom % 16) == 0;
      mr = ($urandom % 6) == 0;
      we = ($urandom % 3) == 0;
      ws = 2'($urandom % 4);
      rs = 2'($urandom % 4);
      wd = $urandom;
      if (ws == 2'd3 && ($urandom % 2) == 0) wd = {19'd0, 2'($urandom % 4), 11'd0};
      step(ec, il, mr, $urandom, we, ws, wd, rs);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule